// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer. It runs on the full-rate input clock. A behavioural dual-modulus prescaler stage divides that clock by P or P+1. Two counters then choose the modulus one prescaler cycle at a time. The swallow counter (A) keeps the prescaler at P+1 for the first A prescaler cycles of every output period. The programmable counter (B) ends the period after B prescaler cycles. One output period therefore spans P×B + A input clock cycles, and this yields division ratios that are not powers of two without a counter running at full rate.

The word (A, B) and the prescaler size select come from an external latch. The block samples them only at a period boundary, so rewriting them partway through a period never distorts the current period. Each period ends with a single-cycle comparison pulse. A flag reports when the word in effect cannot give the ratio P×B + A.

Top module: `psd_divider`

## Requirements
- R1: The spacing between consecutive `div_pulse` assertions is N = P×B + A clock cycles, where P = 64 when `wide_sel` = 0 and P = 128 when `wide_sel` = 1. This holds for any word with B ≥ A and B ≥ 3.
- R2: `mod_ctl` is high for exactly the first A×(P+1) clock cycles of each output period, contiguously from the period boundary, and is low for the rest of the period.
- R3: When A = 0, `mod_ctl` stays low for the entire period.
- R4: `div_pulse` is high for exactly one clock cycle per output period, in the cycle right after the edge at which the counters reload.
- R5: `a_word`, `b_word` and `wide_sel` are sampled only at a reload edge. A change partway through a period leaves that period's length unchanged and takes effect from the next period.
- R6: `cfg_err` is 1 while the word in effect has B < A or B < 3, and 0 otherwise. It is updated only at a reload. With B < A, every prescaler cycle of the period runs at P+1, giving a period of (P+1)×B.
- R7: The reset is synchronous and active low. While it is held, `div_pulse` is 0, and the counters load from the current inputs, so `mod_ctl` = 1 exactly when `a_word` ≠ 0.
- R8: Every prescaler cycle lasts either P or P+1 clock cycles. The choice follows the modulus control in effect for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate input clock (the signal being divided) |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_sel | input | 1 | Prescaler size: 0 selects 64/65, 1 selects 128/129 |
| a_word | input | 7 | Swallow count A (0 to 127) |
| b_word | input | 11 | Programmable count B (3 to 2047) |
| mod_ctl | output | 1 | Modulus control: 1 requests P+1, 0 requests P |
| div_pulse | output | 1 | One-cycle comparison pulse at the end of each period |
| cfg_err | output | 1 | Word in effect violates B ≥ A or B ≥ 3 |

## Verification
The hardest situation to reach from the ports is a word change that lands strictly inside a period. Its effect on the current period is invisible unless the bench measures that period and the next one separately. The bench counts clock cycles from one pulse onward and rewrites the word a fixed number of cycles into the period. It then checks that the period ending at the next pulse still has the old length and that the following period has the new one. Swallow behaviour is observed by counting high cycles of `mod_ctl` over a whole period. This covers A = 0, A = B and A > B.

// File: rtl/psd_pkg.sv
// Package: shared types and helpers for the pulse-swallow divider.
// Assumes: swallow and programmable counts are unsigned binary values.
package psd_pkg;

    // Prescaler size selection
    typedef enum logic {
        PRE_NARROW = 1'b0,
        PRE_WIDE   = 1'b1
    } pre_size_e;

    // Returns 1 when the (a, b) word cannot give P*B + A
    function automatic logic word_invalid(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned min_b);
        return (b < a) || (b < min_b);
    endfunction

endpackage

// File: rtl/psd_prescaler.sv
// Module: behavioural dual-modulus prescaler stage.
// Divides clk by 2**LO_LOG2 or 2**HI_LOG2, plus one when plus1_nxt is set.
// Assumes: size_nxt and plus1_nxt describe the cycle that starts after the
// edge at which tick is high; they are sampled only on that edge (or in reset).
module psd_prescaler
    import psd_pkg::*;
#(
    parameter int LO_LOG2 = 6,
    parameter int HI_LOG2 = 7
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pre_size_e size_nxt,
    input  logic      plus1_nxt,
    output logic      tick
);
    localparam int CW = HI_LOG2 + 1;
    localparam logic [CW-1:0] LO_TOP = CW'((1 << LO_LOG2) - 1);
    localparam logic [CW-1:0] HI_TOP = CW'((1 << HI_LOG2) - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load_val;

    // Choose the terminal count for the next prescaler cycle
    always_comb begin
        load_val = ((size_nxt == PRE_WIDE) ? HI_TOP : LO_TOP) + CW'(plus1_nxt);
    end

    assign tick = (cnt_q == '0);

    // Count down one prescaler cycle, reload at its end
    always_ff @(posedge clk) begin
        if (!rst_n || tick) begin
            cnt_q <= load_val;
        end else begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

endmodule

// File: rtl/psd_swallow.sv
// Module: swallow counter. Holds modulus control high for the first A
// prescaler cycles of a period.
// Assumes: load is high on the edge that starts a new output period.
module psd_swallow #(
    parameter int A_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           load,
    input  logic [A_W-1:0] a_load,
    output logic           mod_ctl,
    output logic           plus1_nxt
);
    logic [A_W-1:0] a_q;
    logic [A_W-1:0] a_nxt;

    // Next swallow count: reload, step on each prescaler cycle, or hold at zero
    always_comb begin
        if (!rst_n || load) begin
            a_nxt = a_load;
        end else if (tick && (a_q != '0)) begin
            a_nxt = a_q - A_W'(1);
        end else begin
            a_nxt = a_q;
        end
    end

    // Swallow count register
    always_ff @(posedge clk) begin
        a_q <= a_nxt;
    end

    assign mod_ctl   = (a_q != '0);
    assign plus1_nxt = (a_nxt != '0);

endmodule

// File: rtl/psd_progctr.sv
// Module: programmable counter. Counts B prescaler cycles per period and
// flags the terminal cycle.
// Assumes: B >= 1 for a meaningful period (B = 0 wraps to 2**B_W).
module psd_progctr #(
    parameter int B_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [B_W-1:0] b_load,
    output logic           terminal
);
    logic [B_W-1:0] b_q;

    assign terminal = tick && (b_q == B_W'(1));

    // Count prescaler cycles down to one, then reload
    always_ff @(posedge clk) begin
        if (!rst_n || terminal) begin
            b_q <= b_load;
        end else if (tick) begin
            b_q <= b_q - B_W'(1);
        end
    end

endmodule

// File: rtl/psd_divider.sv
// Module: pulse-swallow dual-modulus feedback divider (top).
// Combines the prescaler stage with the swallow and programmable counters.
// Each output period lasts P*B + A clock cycles.
// Assumes: the A/B word and size select are held stable by an external
// latch; they are sampled only at a period boundary or during reset.
module psd_divider
    import psd_pkg::*;
#(
    parameter int A_W     = 7,
    parameter int B_W     = 11,
    parameter int LO_LOG2 = 6,
    parameter int HI_LOG2 = 7,
    parameter int MIN_B   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wide_sel,
    input  logic [A_W-1:0] a_word,
    input  logic [B_W-1:0] b_word,
    output logic           mod_ctl,
    output logic           div_pulse,
    output logic           cfg_err
);
    logic      pre_tick;
    logic      reload;
    logic      plus1_nxt;
    logic      pulse_q;
    logic      err_q;
    pre_size_e psel_q;
    pre_size_e size_nxt;

    // Size used for the next prescaler cycle: new value only at a boundary
    always_comb begin
        size_nxt = (!rst_n || reload) ? pre_size_e'(wide_sel) : psel_q;
    end

    psd_prescaler #(
        .LO_LOG2 (LO_LOG2),
        .HI_LOG2 (HI_LOG2)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_nxt  (size_nxt),
        .plus1_nxt (plus1_nxt),
        .tick      (pre_tick)
    );

    psd_swallow #(
        .A_W (A_W)
    ) u_swl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (pre_tick),
        .load      (reload),
        .a_load    (a_word),
        .mod_ctl   (mod_ctl),
        .plus1_nxt (plus1_nxt)
    );

    psd_progctr #(
        .B_W (B_W)
    ) u_prg (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (pre_tick),
        .b_load   (b_word),
        .terminal (reload)
    );

    // Capture size select and word validity at each period boundary
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            psel_q <= pre_size_e'(wide_sel);
            err_q  <= word_invalid(int'(a_word), int'(b_word), MIN_B);
        end
    end

    // Register the one-cycle comparison pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= reload;
        end
    end

    assign div_pulse = pulse_q;
    assign cfg_err   = err_q;

endmodule

// File: rtl/psd_divider_chk.sv
// Module: assertion checker for psd_divider, attached by bind.
// Assumes: it sees the internal prescaler tick, reload and size register.
module psd_divider_chk
    import psd_pkg::*;
#(
    parameter int LO_LOG2 = 6,
    parameter int HI_LOG2 = 7
) (
    input logic      clk,
    input logic      rst_n,
    input logic      pre_tick,
    input logic      reload,
    input logic      mod_ctl,
    input logic      div_pulse,
    input logic      cfg_err,
    input pre_size_e psel_q
);
    localparam int GW = HI_LOG2 + 2;

    logic [GW-1:0] gap_q;
    logic [GW-1:0] base_m1;

    // Count clock edges between prescaler ticks
    always_ff @(posedge clk) begin
        if (!rst_n || pre_tick) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + GW'(1);
        end
    end

    // Shortest legal prescaler cycle minus one, for the size in effect
    always_comb begin
        base_m1 = (psel_q == PRE_WIDE) ? GW'((1 << HI_LOG2) - 1)
                                       : GW'((1 << LO_LOG2) - 1);
    end

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R4
    pulse_after_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> $past(reload));

    // R2
    mc_rise_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_ctl) |-> $past(reload));

    // R5
    size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(psel_q));

    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(cfg_err));

    // R8
    pre_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick |-> ((gap_q == base_m1) || (gap_q == base_m1 + GW'(1))));

endmodule

bind psd_divider psd_divider_chk #(
    .LO_LOG2 (LO_LOG2),
    .HI_LOG2 (HI_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_tick  (pre_tick),
    .reload    (reload),
    .mod_ctl   (mod_ctl),
    .div_pulse (div_pulse),
    .cfg_err   (cfg_err),
    .psel_q    (psel_q)
);

// File: tb/test_psd_divider.sv
`timescale 1ns/1ps
module test_psd_divider;

    typedef struct packed {
        logic        sel;
        logic [6:0]  a;
        logic [10:0] b;
        int unsigned n;
        int unsigned mc;
    } vec_t;

    // Expected N = P*B + A and mod_ctl-high cycles = A*(P+1)
    localparam vec_t VECS [6] = '{
        '{1'b0, 7'd5,   11'd10,  32'd645,  32'd325},
        '{1'b0, 7'd0,   11'd3,   32'd192,  32'd0},
        '{1'b1, 7'd7,   11'd7,   32'd903,  32'd903},
        '{1'b0, 7'd127, 11'd127, 32'd8255, 32'd8255},
        '{1'b0, 7'd1,   11'd3,   32'd193,  32'd65},
        '{1'b0, 7'd0,   11'd100, 32'd6400, 32'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_sel = 1'b0;
    logic [6:0]  a_word = 7'd5;
    logic [10:0] b_word = 11'd10;
    logic        mod_ctl;
    logic        div_pulse;
    logic        cfg_err;

    int checks = 0;
    int fails  = 0;

    logic        nx_sel;
    logic [6:0]  nx_a;
    logic [10:0] nx_b;

    always #4 clk = ~clk;

    psd_divider i_psd_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_sel  (wide_sel),
        .a_word    (a_word),
        .b_word    (b_word),
        .mod_ctl   (mod_ctl),
        .div_pulse (div_pulse),
        .cfg_err   (cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Count negedges up to and including the next pulse; optionally
    // rewrite the word at cycle chg_at (0 = never)
    task automatic wait_pulse(input int chg_at, output int cyc, output int mcs,
                              output bit first_hi);
        cyc = 0;
        mcs = 0;
        first_hi = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (mod_ctl) mcs++;
            if (cyc == 1 && div_pulse) first_hi = 1'b1;
            if (chg_at != 0 && cyc == chg_at) begin
                wide_sel = nx_sel;
                a_word   = nx_a;
                b_word   = nx_b;
            end
            if (div_pulse || cyc >= 40000) break;
        end
    endtask

    task automatic set_word(input logic s, input logic [6:0] a, input logic [10:0] b);
        wide_sel = s;
        a_word   = a;
        b_word   = b;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        int cyc, mcs;
        bit fh;

        // R7: reset state
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R7 pulse low in reset", int'(div_pulse), 0);
        check(mod_ctl == 1'b1, "R7 mod_ctl follows A!=0 in reset", int'(mod_ctl), 1);
        check(cfg_err == 1'b0, "R6 valid word in reset", int'(cfg_err), 0);
        a_word = 7'd0;
        @(negedge clk);
        check(mod_ctl == 1'b0, "R7 reset loads A=0", int'(mod_ctl), 0);
        a_word = 7'd5;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        wait_pulse(0, cyc, mcs, fh);
        check(div_pulse == 1'b1, "R4 first pulse after reset", int'(div_pulse), 1);

        // R1, R2, R3, R8: table of words
        for (int i = 0; i < 6; i++) begin
            set_word(VECS[i].sel, VECS[i].a, VECS[i].b);
            wait_pulse(0, cyc, mcs, fh);
            wait_pulse(0, cyc, mcs, fh);
            check(cyc == int'(VECS[i].n), "R1 R8 period length", cyc, int'(VECS[i].n));
            check(mcs == int'(VECS[i].mc), (VECS[i].a == 0) ? "R3 no swallow" : "R2 swallow cycles",
                  mcs, int'(VECS[i].mc));
            check(!fh, "R4 single-cycle pulse", int'(fh), 0);
            check(cfg_err == 1'b0, "R6 valid word", int'(cfg_err), 0);
        end

        // R5: word rewritten 50 cycles into a period (old word: 64*100+0)
        nx_sel = 1'b1;
        nx_a   = 7'd3;
        nx_b   = 11'd4;
        wait_pulse(50, cyc, mcs, fh);
        check(cyc == 6400, "R5 current period keeps old word", cyc, 6400);
        wait_pulse(0, cyc, mcs, fh);
        check(cyc == 515, "R5 new word next period", cyc, 515);
        check(mcs == 387, "R5 R2 new swallow count", mcs, 387);

        // R6: B < A gives (P+1)*B and raises the flag
        set_word(1'b0, 7'd10, 11'd5);
        check(cfg_err == 1'b0, "R6 flag waits for reload", int'(cfg_err), 0);
        wait_pulse(0, cyc, mcs, fh);
        wait_pulse(0, cyc, mcs, fh);
        check(cyc == 325, "R6 B<A period", cyc, 325);
        check(mcs == 325, "R6 B<A all at P+1", mcs, 325);
        check(cfg_err == 1'b1, "R6 B<A flagged", int'(cfg_err), 1);

        // R6: B below minimum
        set_word(1'b0, 7'd0, 11'd2);
        wait_pulse(0, cyc, mcs, fh);
        wait_pulse(0, cyc, mcs, fh);
        check(cyc == 128, "R6 B=2 period", cyc, 128);
        check(cfg_err == 1'b1, "R6 B<3 flagged", int'(cfg_err), 1);

        // R6: flag clears on a valid word
        set_word(1'b0, 7'd1, 11'd3);
        wait_pulse(0, cyc, mcs, fh);
        wait_pulse(0, cyc, mcs, fh);
        check(cyc == 193, "R1 smallest valid B", cyc, 193);
        check(cfg_err == 1'b0, "R6 flag cleared", int'(cfg_err), 0);

        summary();
        $finish;
    end

endmodule